// File: doc/BRIEF.md
# Ring Packet Scrubber

This node sits once on a ring bus. Its job is to stop packets from circling the ring for ever. It has a Valid/Accept input port and a Valid/Accept output port. It carries packets of one or more words. The first word of each packet is a header, and a last-word flag marks the final word. One bit of the header's command field records whether the packet has already passed this node.

When a header arrives with that bit clear, the node sets the bit and forwards the whole packet. Every other bit is left as it was. When a header arrives with the bit already set, the packet has made a full lap without being taken off, so the node discards it. The node drops every word up to and including the word flagged as last. While it drops, it keeps accepting input, so the dropping never stalls the ring.

A count of discarded packets is visible at a port for checking. The data width, the position of the marker bit and the counter width are parameters.

Top module: `ring_scrubber`

## Requirements
- R1: A header (the first word after reset or after a word with `inLast` high) with bit `DIRTY_POS` clear is forwarded with bit `DIRTY_POS` set and every other bit unchanged.
- R2: The payload words of a forwarded packet leave unchanged, in arrival order, with their `inLast` value copied to `outLast`, even when a payload word has bit `DIRTY_POS` set.
- R3: A header with bit `DIRTY_POS` set causes that header and every later word up to and including the one with `inLast` high to be discarded, so none of them appears at the output.
- R4: While a packet is being discarded, `inAccept` is high whatever the state of `outAccept`. A discarded word never raises `outValid`.
- R5: `dropCount` rises by exactly one for each discarded packet, in the cycle after its header is taken in, and is otherwise unchanged.
- R6: A single-word packet (its header has `inLast` high) is handled as a complete packet. The next word is treated as a new header.
- R7: A word moves only when valid and accept are both high. While `outValid` is high and `outAccept` is low, `outData` and `outLast` hold steady and `outValid` stays high.
- R8: Reset clears `outValid` and `dropCount` and makes the next input word a header, even if reset came in the middle of a packet.
- R9: With `outAccept` held high, `inAccept` is high on every cycle, so forwarding runs at one word per cycle. A forwarded word appears at the output one clock after it is taken in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Upstream word present |
| inData | input | DATA_W | Upstream word |
| inLast | input | 1 | Upstream word ends its packet |
| inAccept | output | 1 | Node can take the upstream word |
| outValid | output | 1 | Downstream word present |
| outData | output | DATA_W | Downstream word |
| outLast | output | 1 | Downstream word ends its packet |
| outAccept | input | 1 | Downstream takes the word |
| dropCount | output | CNT_W | Number of packets discarded since reset |

## Verification
Two functions can fall in the same cycle. The node can be discarding words of a marked packet while a word it forwarded earlier still waits in the output register, because downstream is not accepting. The bench provokes this by holding `outAccept` low and parking a clean single-word packet in the output. It then sends a four-word marked packet and requires `inAccept` to be high on every one of its words. It also requires the parked word to stay put and unchanged, and to come out alone once `outAccept` returns. A second overlap is a new word loading in the same cycle that the previous word leaves. Random back-pressure produces it, and the scoreboard judges it by word order and by the absence of duplicates or losses.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  // Packet position as seen by the control logic
  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,  // next word is a header
    ST_PASS = 2'd1,  // forwarding the rest of a clean packet
    ST_DROP = 2'd2   // discarding the rest of a marked packet
  } scrubState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // capture the input word into the output register
    logic markDirty;  // the captured word is a header: set its marker bit
  } dpStrobe_t;

endpackage

// File: rtl/scrub_datapath.sv
module scrub_datapath
  import scrub_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DIRTY_POS = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  input  logic              outAccept,
  output logic              canLoad,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outLast
);

  logic [DATA_W-1:0] nextWord;
  logic              validQ;
  logic [DATA_W-1:0] dataQ;
  logic              lastQ;

  // Per-bit select: only the marker position can be altered
  for (genvar g = 0; g < DATA_W; g++) begin : gBit
    if (g == DIRTY_POS) begin : gMark
      assign nextWord[g] = inData[g] | strobe.markDirty;
    end else begin : gCopy
      assign nextWord[g] = inData[g];
    end
  end

  // The register may be refilled when it is empty or being emptied now
  assign canLoad = !validQ || outAccept;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (strobe.load) begin
      validQ <= 1'b1;
    end else if (outAccept) begin
      validQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      dataQ <= nextWord;
      lastQ <= inLast;
    end
  end

  assign outValid = validQ;
  assign outData  = dataQ;
  assign outLast  = lastQ;

endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl
  import scrub_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inDirty,
  input  logic             inLast,
  input  logic             canLoad,
  output logic             inAccept,
  output dpStrobe_t        strobe,
  output logic [CNT_W-1:0] dropCount
);

  scrubState_t state, stateNext;
  logic        dropWord;
  logic        xfer;
  logic        hdrDrop;
  logic [CNT_W-1:0] cntQ;

  // A word is thrown away if it is a marked header or follows one
  assign dropWord = (state == ST_DROP) || ((state == ST_HDR) && inDirty);

  // Discarded words need no room downstream
  assign inAccept = dropWord || canLoad;
  assign xfer     = inValid && inAccept;
  assign hdrDrop  = xfer && (state == ST_HDR) && inDirty;

  always_comb begin
    strobe.load      = xfer && !dropWord;
    strobe.markDirty = (state == ST_HDR);
  end

  always_comb begin
    stateNext = state;
    if (xfer) begin
      unique case (state)
        ST_HDR: begin
          if (inLast)       stateNext = ST_HDR;
          else if (inDirty) stateNext = ST_DROP;
          else              stateNext = ST_PASS;
        end
        ST_PASS: if (inLast) stateNext = ST_HDR;
        ST_DROP: if (inLast) stateNext = ST_HDR;
        default: stateNext = ST_HDR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_HDR;
    else       state <= stateNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        cntQ <= '0;
    else if (hdrDrop) cntQ <= cntQ + 1'b1;
  end

  assign dropCount = cntQ;

endmodule

// File: rtl/ring_scrubber.sv
module ring_scrubber
  import scrub_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DIRTY_POS = 31,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  output logic              inAccept,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outLast,
  input  logic              outAccept,
  output logic [CNT_W-1:0]  dropCount
);

  dpStrobe_t strobe;
  logic      canLoad;

  scrub_ctrl #(
    .CNT_W(CNT_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inDirty  (inData[DIRTY_POS]),
    .inLast   (inLast),
    .canLoad  (canLoad),
    .inAccept (inAccept),
    .strobe   (strobe),
    .dropCount(dropCount)
  );

  scrub_datapath #(
    .DATA_W   (DATA_W),
    .DIRTY_POS(DIRTY_POS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inData   (inData),
    .inLast   (inLast),
    .outAccept(outAccept),
    .canLoad  (canLoad),
    .outValid (outValid),
    .outData  (outData),
    .outLast  (outLast)
  );

endmodule

// File: rtl/ring_scrubber_chk.sv
module ring_scrubber_chk #(
  parameter int DATA_W    = 32,
  parameter int DIRTY_POS = 31,
  parameter int CNT_W     = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] inData,
  input logic              inLast,
  input logic              inAccept,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              outLast,
  input logic              outAccept,
  input logic [CNT_W-1:0]  dropCount
);

  // Packet framing rebuilt from the ports alone
  logic expHdr;
  logic dropping;
  logic inXfer;
  logic curDrop;
  logic hdrDropXfer;

  assign inXfer      = inValid && inAccept;
  assign curDrop     = expHdr ? inData[DIRTY_POS] : dropping;
  assign hdrDropXfer = inXfer && expHdr && inData[DIRTY_POS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expHdr   <= 1'b1;
      dropping <= 1'b0;
    end else if (inXfer) begin
      expHdr <= inLast;
      if (expHdr) dropping <= inData[DIRTY_POS];
    end
  end

  // R1: clean header comes out marked
  a_r1_mark_header: assert property (@(posedge clk) disable iff (!rstN)
    inXfer && expHdr && !inData[DIRTY_POS] |=> outValid && outData[DIRTY_POS]);

  // R2: payload of a clean packet is copied untouched
  a_r2_payload_copy: assert property (@(posedge clk) disable iff (!rstN)
    inXfer && !expHdr && !dropping |=>
      outValid && (outData == $past(inData)) && (outLast == $past(inLast)));

  // R3: a discarded word never shows up at the output
  a_r3_no_output: assert property (@(posedge clk) disable iff (!rstN)
    inXfer && curDrop && (!outValid || outAccept) |=> !outValid);

  // R4: discarding never back-pressures upstream
  a_r4_drop_accepts: assert property (@(posedge clk) disable iff (!rstN)
    (!expHdr && dropping) || (expHdr && inValid && inData[DIRTY_POS]) |-> inAccept);

  // R5: counter steps by one per discarded packet
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rstN)
    hdrDropXfer |=> dropCount == $past(dropCount) + 1'b1);

  a_r5_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    !hdrDropXfer |=> $stable(dropCount));

  // R7: a stalled output word is held
  a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outAccept |=> outValid && $stable(outData) && $stable(outLast));

  // R9: no back-pressure when downstream always accepts
  a_r9_full_rate: assert property (@(posedge clk) disable iff (!rstN)
    outAccept |-> inAccept);

endmodule

bind ring_scrubber ring_scrubber_chk #(
  .DATA_W   (DATA_W),
  .DIRTY_POS(DIRTY_POS),
  .CNT_W    (CNT_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inData   (inData),
  .inLast   (inLast),
  .inAccept (inAccept),
  .outValid (outValid),
  .outData  (outData),
  .outLast  (outLast),
  .outAccept(outAccept),
  .dropCount(dropCount)
);

// File: tb/ring_scrubber_tb_top.sv
`timescale 1ns/1ps
module ring_scrubber_tb_top;

  localparam int DW    = 32;
  localparam int DPOS  = 31;
  localparam int CW    = 16;
  localparam logic [DW-1:0] MARK = DW'(1) << DPOS;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [DW-1:0] inData = '0;
  logic          inLast = 1'b0;
  logic          inAccept;
  logic          outValid;
  logic [DW-1:0] outData;
  logic          outLast;
  logic          outAccept = 1'b1;
  logic [CW-1:0] dropCount;

  int total = 0;
  int bad   = 0;
  int expDrops = 0;
  int stallMode = 0;   // 0 always accept, 1 random, 2 never
  logic [7:0] lfsr = 8'hA5;

  logic [DW:0] expQ[$];   // {last, data}

  always #4 clk = ~clk;   // 125 MHz

  ring_scrubber #(.DATA_W(DW), .DIRTY_POS(DPOS), .CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inLast(inLast),
    .inAccept(inAccept), .outValid(outValid), .outData(outData), .outLast(outLast),
    .outAccept(outAccept), .dropCount(dropCount)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Downstream back-pressure pattern
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (stallMode)
      0:       outAccept <= 1'b1;
      1:       outAccept <= lfsr[0] | lfsr[2];
      default: outAccept <= 1'b0;
    endcase
  end

  // Monitor: scoreboard pop and hold check
  logic          prevHeld = 1'b0;
  logic [DW-1:0] prevData;
  logic          prevLast;
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      if (prevHeld)
        check(outValid && outData == prevData && outLast == prevLast, "R7",
              "stalled word changed", {31'd0, outValid, outData}, {31'd1, prevData});
      if (outValid && outAccept) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3", "unexpected output word", {31'd0, outLast, outData}, 64'd0);
        end else begin
          logic [DW:0] e;
          e = expQ.pop_front();
          check({outLast, outData} == e, "R1/R2", "output word mismatch",
                {31'd0, outLast, outData}, {31'd0, e});
        end
      end
      prevHeld = outValid && !outAccept;
      prevData = outData;
      prevLast = outLast;
    end else begin
      prevHeld = 1'b0;
    end
  end

  // Drive one word; called at a falling edge, returns at the next one
  task automatic sendWord(input logic [DW-1:0] d, input bit last, input bit drop,
                          input logic [DW-1:0] expD);
    bit first = 1'b1;
    inValid = 1'b1;
    inData  = d;
    inLast  = last;
    forever begin
      #2;
      if (first && drop)
        check(inAccept, "R4", "discarded word not accepted", {63'd0, inAccept}, 64'd1);
      if (first && !drop && stallMode == 0)
        check(inAccept, "R9", "stall with downstream ready", {63'd0, inAccept}, 64'd1);
      first = 1'b0;
      if (inAccept) break;
      @(negedge clk);
    end
    if (!drop) expQ.push_back({last, expD});
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic sendPacket(input int len, input bit dirty, input logic [DW-1:0] seed);
    logic [DW-1:0] hdr;
    hdr = dirty ? (seed | MARK) : (seed & ~MARK);
    sendWord(hdr, len == 1, dirty, hdr | MARK);
    if (dirty) expDrops++;
    for (int i = 1; i < len; i++) begin
      logic [DW-1:0] w;
      w = seed ^ (DW'(i) * 32'h9E37_79B9);
      sendWord(w, i == len - 1, dirty, w);
    end
  endtask

  task automatic drain();
    stallMode = 0;
    for (int i = 0; i < 60 && expQ.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R2", "words missing after drain", 64'(expQ.size()), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    // R8: reset state
    check(!outValid, "R8", "outValid after reset", {63'd0, outValid}, 64'd0);
    check(dropCount == 0, "R8", "dropCount after reset", 64'(dropCount), 64'd0);
    check(inAccept, "R8", "inAccept after reset", {63'd0, inAccept}, 64'd1);
    @(negedge clk);

    // R1 R2 R9: clean packets back to back, payload with marker bit set
    sendPacket(4, 1'b0, 32'h1234_5678);
    sendPacket(3, 1'b0, 32'hFFFF_0001);
    sendPacket(5, 1'b0, 32'h0F0F_F0F0);
    drain();

    // R3 R5: marked packets interleaved with clean ones
    sendPacket(3, 1'b1, 32'h2222_3333);
    sendPacket(2, 1'b0, 32'h4444_5555);
    sendPacket(6, 1'b1, 32'h6666_7777);
    sendPacket(2, 1'b0, 32'h8888_9999);
    drain();
    check(dropCount == CW'(expDrops), "R5", "dropCount after mix", 64'(dropCount), 64'(expDrops));

    // R6: single-word packets
    sendPacket(1, 1'b0, 32'h0000_00AA);
    sendPacket(1, 1'b1, 32'h0000_00BB);
    sendPacket(1, 1'b0, 32'h0000_00CC);
    sendPacket(1, 1'b1, 32'h0000_00DD);
    sendPacket(3, 1'b0, 32'h0000_00EE);
    drain();
    check(dropCount == CW'(expDrops), "R6", "dropCount after single words", 64'(dropCount), 64'(expDrops));

    // R7: random back-pressure
    stallMode = 1;
    for (int p = 0; p < 24; p++)
      sendPacket(1 + (p % 5), (p % 3) == 1, 32'hC0DE_0000 + DW'(p * 97));
    drain();
    check(dropCount == CW'(expDrops), "R5", "dropCount after stress", 64'(dropCount), 64'(expDrops));

    // R4: discard while output is stalled
    stallMode = 2;
    @(negedge clk);
    sendPacket(1, 1'b0, 32'h0BAD_F00D);
    sendPacket(4, 1'b1, 32'h5555_AAAA);
    #2;
    check(outValid && outData == (32'h0BAD_F00D | MARK), "R4", "parked word disturbed by drop",
          {31'd0, outValid, outData}, {31'd1, 32'h0BAD_F00D | MARK});
    @(negedge clk);
    drain();
    check(dropCount == CW'(expDrops), "R4", "dropCount after stalled drop", 64'(dropCount), 64'(expDrops));

    // R8: reset mid-packet, then next word is a header
    stallMode = 2;
    @(negedge clk);
    inValid = 1'b1; inData = 32'h0101_0101; inLast = 1'b0;
    @(negedge clk);
    inValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    expQ.delete();
    expDrops = 0;
    #2;
    check(dropCount == 0 && !outValid, "R8", "state after mid-packet reset",
          {31'd0, outValid, 16'd0, dropCount}, 64'd0);
    @(negedge clk);
    stallMode = 0;
    @(negedge clk);
    sendPacket(1, 1'b1, 32'h7777_0000);
    sendPacket(2, 1'b0, 32'h0000_1111);
    drain();
    check(dropCount == 1, "R8", "header expected after reset", 64'(dropCount), 64'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule